// File: doc/BRIEF.md
# PHY Status Auto-Poll Monitor

This block watches a PHY's status register without host involvement. While its enable input is high it asks a neighbouring MDIO frame master for a status read. It waits a programmable number of cycles, then asks again. It keeps the latest good value in a shadow register and flags any change it sees in later reads.

The first good read after the enable goes high only fills the shadow register. Each later good read is compared with the shadow register before it overwrites it. A difference sets a sticky change flag, and the host clears that flag by pulsing a clear input.

The interrupt output is the flag gated by an interrupt-enable input. A read that the frame master marks as failed is dropped without any effect. A host-side management access always wins over a poll: a poll request is only raised while the master reports that it is not busy.

Top module: `auto_poll_monitor`

## Requirements
- R1: When `poll_en` is low, `req` never rises. A request already raised stays up until it is acknowledged.
- R2: After `poll_en` goes high from an idle block with `mgmt_busy` low, `req` rises after two clock edges. After each acknowledged poll, `req` stays low for at least `poll_gap`+2 cycles before it rises again.
- R3: `req` rises only if `mgmt_busy` was low at the preceding clock edge. While `mgmt_busy` stays high, no new request is raised.
- R4: Once raised, `req` stays high until a cycle with `ack` high. It falls right after that cycle. A read completes in a cycle with both `req` and `ack` high.
- R5: The first completed, error-free read after `poll_en` goes high is stored in `shadow` and does not set the change flag.
- R6: Each later error-free read is compared with `shadow`. A mismatch sets the change flag. `shadow` takes the read value on every error-free read, and it changes at no other time.
- R7: A read completed with `rd_err` high leaves `shadow` and the flag unchanged.
- R8: `irq` is registered and equals the change flag ANDed with `irq_en`, one cycle later. The flag is kept while `irq_en` is low, and `irq` rises if `irq_en` is raised later.
- R9: A pulse on `irq_clr` clears the flag. A mismatch in the same cycle wins, and the flag stays set.
- R10: Dropping `poll_en` forgets that a first read was taken, so the next enable starts with a store-only read. A read that completes while `poll_en` is low is ignored.
- R11: Synchronous reset drives `req`, `irq` and `shadow` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Auto-poll enable |
| poll_gap | input | GAP_W | Idle cycles between polls |
| mgmt_busy | input | 1 | Frame master busy or host access pending |
| req | output | 1 | Status read request to the frame master |
| ack | input | 1 | One-cycle read completion strobe |
| rd_data | input | DATA_W | Status value returned with `ack` |
| rd_err | input | 1 | Read failed (bad turnaround), valid with `ack` |
| irq_en | input | 1 | Status-change interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the change flag |
| irq | output | 1 | Gated status-change interrupt |
| shadow | output | DATA_W | Last good status value |

## Verification
The properties assume that the frame master pulses `ack` for exactly one cycle, only while `req` is high. They also assume that `rd_data` and `rd_err` are valid in that cycle, and that `poll_gap` is read at the completion edge. The bench's responder changes signals only on falling edges. It answers a raised request after 0 to 3 cycles with a single-cycle `ack`, and drops `ack` on the next falling edge. Random traffic on `mgmt_busy`, `irq_en`, `irq_clr` and `poll_en` is applied only at falling edges, so every input is stable around each rising edge.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ARB  = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } poll_state_t;
endpackage

// File: rtl/apoll_timer.sv
module apoll_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             expired
);
  logic [GAP_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expired = (count == '0);
endmodule

// File: rtl/apoll_seq.sv
module apoll_seq
  import apoll_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic poll_en,
  input  logic mgmt_busy,
  input  logic ack,
  input  logic timer_expired,
  output logic req,
  output logic timer_load
);
  poll_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
    end else begin
      case (state)
        ST_OFF:  if (poll_en) state <= ST_ARB;
        ST_ARB: begin
          if (!poll_en)        state <= ST_OFF;
          else if (!mgmt_busy) state <= ST_REQ;
        end
        ST_REQ:  if (ack) state <= poll_en ? ST_WAIT : ST_OFF;
        ST_WAIT: begin
          if (!poll_en)           state <= ST_OFF;
          else if (timer_expired) state <= ST_ARB;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign req        = (state == ST_REQ);
  assign timer_load = (state == ST_REQ) && ack;
endmodule

// File: rtl/apoll_shadow.sv
module apoll_shadow #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_en,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] shadow,
  output logic              irq
);
  logic primed;
  logic flag;
  logic good_rd;
  logic mismatch;

  assign good_rd  = rd_fire && !rd_err && poll_en;
  assign mismatch = good_rd && primed && (rd_data != shadow);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      primed <= 1'b0;
    end else begin
      if (good_rd) shadow <= rd_data;
      if (!poll_en)     primed <= 1'b0;
      else if (good_rd) primed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= irq_en && flag;
      if (mismatch)     flag <= 1'b1;
      else if (irq_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/auto_poll_monitor.sv
module auto_poll_monitor #(
  parameter int DATA_W = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_en,
  input  logic [GAP_W-1:0]  poll_gap,
  input  logic              mgmt_busy,
  output logic              req,
  input  logic              ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              irq,
  output logic [DATA_W-1:0] shadow
);
  logic timer_load;
  logic timer_expired;
  logic rd_fire;

  apoll_timer #(.GAP_W(GAP_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (poll_gap),
    .expired  (timer_expired)
  );

  apoll_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .poll_en       (poll_en),
    .mgmt_busy     (mgmt_busy),
    .ack           (ack),
    .timer_expired (timer_expired),
    .req           (req),
    .timer_load    (timer_load)
  );

  assign rd_fire = req && ack;

  apoll_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .poll_en (poll_en),
    .rd_fire (rd_fire),
    .rd_data (rd_data),
    .rd_err  (rd_err),
    .irq_en  (irq_en),
    .irq_clr (irq_clr),
    .shadow  (shadow),
    .irq     (irq)
  );
endmodule

// File: rtl/apoll_checker.sv
module apoll_checker #(
  parameter int DATA_W = 16,
  parameter int GAP_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              poll_en,
  input logic [GAP_W-1:0]  poll_gap,
  input logic              mgmt_busy,
  input logic              req,
  input logic              ack,
  input logic              rd_err,
  input logic              irq_en,
  input logic              irq,
  input logic [DATA_W-1:0] shadow
);
  localparam int CW = GAP_W + 2;
  logic [CW-1:0]    low_cnt;
  logic [GAP_W-1:0] gap_hold;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      gap_hold <= '0;
      armed    <= 1'b0;
    end else if (req && ack) begin
      low_cnt  <= '0;
      gap_hold <= poll_gap;
      armed    <= poll_en;
    end else begin
      if (!req && low_cnt != {CW{1'b1}}) low_cnt <= low_cnt + 1'b1;
      if (!poll_en) armed <= 1'b0;
    end
  end

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    (!poll_en && !req) |=> !req);

  a_r2_min_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(req) && armed) |-> (low_cnt >= ({2'b00, gap_hold} + CW'(2))));

  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (!req && mgmt_busy) |=> !req);

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);

  a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);

  a_r6_shadow_only_on_read: assert property (@(posedge clk) disable iff (rst)
    !(req && ack) |=> $stable(shadow));

  a_r7_err_keeps_shadow: assert property (@(posedge clk) disable iff (rst)
    (req && ack && rd_err) |=> $stable(shadow));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));
endmodule

bind auto_poll_monitor apoll_checker #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .poll_en   (poll_en),
  .poll_gap  (poll_gap),
  .mgmt_busy (mgmt_busy),
  .req       (req),
  .ack       (ack),
  .rd_err    (rd_err),
  .irq_en    (irq_en),
  .irq       (irq),
  .shadow    (shadow)
);

// File: tb/auto_poll_monitor_tb.sv
module auto_poll_monitor_tb;
  localparam int DW = 16;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          poll_en;
  logic [GW-1:0] poll_gap;
  logic          mgmt_busy;
  logic          req;
  logic          ack;
  logic [DW-1:0] rd_data;
  logic          rd_err;
  logic          irq_en;
  logic          irq_clr;
  logic          irq;
  logic [DW-1:0] shadow;

  always #5 clk = ~clk;

  auto_poll_monitor #(.DATA_W(DW), .GAP_W(GW)) u_dut (
    .clk(clk), .rst(rst), .poll_en(poll_en), .poll_gap(poll_gap),
    .mgmt_busy(mgmt_busy), .req(req), .ack(ack), .rd_data(rd_data),
    .rd_err(rd_err), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
    .shadow(shadow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] phy_status;
  logic          phy_err;
  int            lat_cfg;

  logic [DW-1:0] m_shadow;
  logic          m_primed, m_flag, m_irq;
  logic          prev_req, prev_busy, prev_en, armed;
  int            lowcnt, gap_hold;
  int            polls = 0;
  int            rises = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit differs(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a != b;
  endfunction

  // reference model and protocol monitors
  always @(posedge clk) begin
    bit fire, setf;
    if (rst) begin
      m_shadow = '0; m_primed = 0; m_flag = 0; m_irq = 0;
      prev_req = 0; prev_busy = 0; prev_en = 0; armed = 0; lowcnt = 0; gap_hold = 0;
    end else begin
      if (req && !prev_req) begin
        rises++;
        chk(prev_busy == 0, "R3", "req rose after busy", prev_busy, 0);
        chk(prev_en == 1, "R1", "req rose while disabled", prev_en, 1);
        if (armed) chk(lowcnt >= gap_hold + 2, "R2", "poll gap", lowcnt, gap_hold + 2);
      end
      m_irq = irq_en && m_flag;
      fire  = req && ack;
      setf  = 0;
      if (fire && !rd_err && poll_en) begin
        if (m_primed && differs(rd_data, m_shadow)) setf = 1;
        m_shadow = rd_data;
        m_primed = 1;
      end
      if (!poll_en) m_primed = 0;
      if (setf) m_flag = 1;
      else if (irq_clr) m_flag = 0;
      if (fire) begin
        polls++; lowcnt = 0; gap_hold = int'(poll_gap); armed = poll_en;
      end else if (!req) begin
        lowcnt++;
      end
      if (!poll_en) armed = 0;
      prev_req = req; prev_busy = mgmt_busy; prev_en = poll_en;
    end
  end

  // frame master responder
  initial begin
    int wcnt;
    wcnt = 0;
    ack = 0; rd_data = '0; rd_err = 0; lat_cfg = 1;
    forever begin
      @(negedge clk);
      if (ack) ack = 0;
      else if (req) begin
        if (wcnt >= lat_cfg) begin
          ack = 1; rd_data = phy_status; rd_err = phy_err; wcnt = 0;
          lat_cfg = $urandom_range(0, 3);
        end else wcnt++;
      end
    end
  end

  task automatic wait_polls(input int n);
    int target;
    target = polls + n;
    while (polls < target) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_pulse();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n, r0;
    void'($urandom(32'h1A2B));
    rst = 1; poll_en = 0; poll_gap = 8'd4; mgmt_busy = 0; irq_en = 1; irq_clr = 0;
    phy_status = 16'h7809; phy_err = 0;
    idle(5);
    chk(req == 0, "R11", "req after reset", req, 0);
    chk(irq == 0, "R11", "irq after reset", irq, 0);
    chk(shadow == 0, "R11", "shadow after reset", shadow, 0);
    rst = 0;

    idle(20);
    chk(rises == 0, "R1", "requests while disabled", rises, 0);

    poll_en = 1; n = 0;
    while (!req && n < 10) begin @(negedge clk); n++; end
    chk(n == 2, "R2", "edges to first request", n, 2);

    wait_polls(1); idle(2);
    chk(shadow == 16'h7809, "R5", "first read stored", shadow, 16'h7809);
    chk(irq == 0, "R5", "first read no irq", irq, 0);

    phy_status = 16'h780D;
    wait_polls(2); idle(2);
    chk(shadow == 16'h780D, "R6", "shadow follows read", shadow, 16'h780D);
    chk(irq == 1, "R6", "change raises irq", irq, 1);

    clr_pulse(); idle(2);
    chk(irq == 0, "R9", "clear drops irq", irq, 0);

    irq_en = 0; phy_status = 16'h7800;
    wait_polls(2); idle(2);
    chk(irq == 0, "R8", "irq masked", irq, 0);
    chk(shadow == 16'h7800, "R6", "shadow while masked", shadow, 16'h7800);
    irq_en = 1; idle(2);
    chk(irq == 1, "R8", "flag kept while masked", irq, 1);
    clr_pulse(); idle(2);

    phy_err = 1; phy_status = 16'h1234;
    wait_polls(2); idle(2);
    chk(shadow == 16'h7800, "R7", "error read not stored", shadow, 16'h7800);
    chk(irq == 0, "R7", "error read no irq", irq, 0);
    phy_err = 0; phy_status = 16'h7800;

    wait_polls(1);
    mgmt_busy = 1; idle(6); r0 = rises; idle(40);
    chk(rises == r0, "R3", "no request while busy", rises, r0);
    mgmt_busy = 0;
    wait_polls(1);

    poll_en = 0; idle(10); r0 = rises; idle(20);
    chk(rises == r0, "R1", "no request after disable", rises, r0);
    phy_status = 16'h4321; poll_en = 1;
    wait_polls(1); idle(2);
    chk(shadow == 16'h4321, "R10", "store after re-enable", shadow, 16'h4321);
    chk(irq == 0, "R10", "re-enable read store-only", irq, 0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chk(irq === m_irq, "R8", "irq vs model", irq, m_irq);
      chk(shadow === m_shadow, "R6", "shadow vs model", shadow, m_shadow);
      mgmt_busy = ($urandom_range(0, 9) < 3);
      if ($urandom_range(0, 4) == 0) phy_status = 16'h7800 | 16'($urandom_range(0, 3));
      phy_err = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 9) == 0) irq_en = ~irq_en;
      irq_clr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) poll_en = ~poll_en;
      if ($urandom_range(0, 99) == 0) poll_gap = 8'($urandom_range(0, 7));
    end
    irq_clr = 0;
    idle(2);
    summary();
  end
endmodule